// File: doc/BRIEF.md
# Two-Wire Master Command Sequencer

This block sits between software-style command requests and a bit-level two-wire (I2C) master. A caller presents one command: a 7-bit target address, a read or write direction, a byte count, an optional register offset of zero, one or two bytes, and up to eight bytes of write data. The sequencer checks that the command is legal, packs it into the field layout that the transfer layer expects, issues it, and waits for completion under a cycle timeout.

When the transfer layer reports a result, the status code is classified. Lost-arbitration and target-busy codes lead to a back-off pause and a new attempt. Any other failure ends the command at once. A transfer that never completes triggers a bus-recovery request before the command is tried again. Timeouts and back-off retries draw on one shared retry budget. A successful write is followed by acknowledge polling: one-byte reads without an offset, repeated until the target answers or the poll limit runs out. Read data is trimmed to the requested byte count before it is returned.

Top module: `twi_cmd_engine`

## Requirements
- R1: A command with a read length outside 1..4, a write length outside 1..8, or an offset length code of 3 ends with `res_done` and `res_err` high one cycle after `cmd_start`, and no transfer is issued.
- R2: Each issued transfer presents the target address on `xfr_dev`, the direction on `xfr_read` (1 = read) and the byte count minus one on `xfr_size`.
- R3: A nonzero offset length sets `xfr_op_ia`; offset bits 7:3 appear on `xfr_ia_hi` and bits 2:0 on `xfr_ia_lo`; with a two-byte offset `xfr_ext_en` is set and bits 15:8 appear on `xfr_ext_ia`; with no offset all of these fields are zero.
- R4: A write presents data bits 31:0 on `xfr_data`; bits 63:32 appear on `xfr_ext_data` only when more than four bytes are written, otherwise that field is zero.
- R5: A transfer not completed within TIMEOUT_CYC cycles after issue raises `rcv_req`; once `rcv_done` returns, the command is issued again. Completion arriving in the final cycle of the window counts as completion and no recovery is requested.
- R6: A failed transfer whose status is one of 0x38, 0x68, 0x78, 0x80, 0x88, 0xA0, 0xA8, 0xB0, 0xB8, 0xC8 is reissued after a pause of at least RETRY_DELAY_CYC cycles.
- R7: A failed transfer with any other status ends the command with an error and no further transfer.
- R8: Timeouts and back-off retries share one budget of MAX_RETRY reissues; once it is spent, the next failure of either kind ends the command with an error.
- R9: A successful read returns the transfer data masked to the low 8 × byte-count bits.
- R10: After a successful write, one-byte reads to the same target with no offset are issued until one succeeds (command succeeds) or POLL_MAX of them fail (command errors).
- R11: `cmd_start` is ignored while `busy` is high.
- R12: `res_done` is a single-cycle pulse, and `busy` is high from the cycle after an accepted start until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for a new command |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | Target address |
| cmd_ia | input | 16 | Register offset |
| cmd_ia_len | input | 2 | Offset length in bytes (0, 1, 2) |
| cmd_nbytes | input | 4 | Data byte count |
| cmd_wdata | input | 64 | Write data, low bytes valid |
| busy | output | 1 | Command in progress |
| res_done | output | 1 | Command finished (one-cycle pulse) |
| res_err | output | 1 | Command failed, valid with res_done |
| res_rdata | output | 32 | Masked read data, valid with res_done |
| xfr_issue | output | 1 | Transfer issue pulse |
| xfr_pending | output | 1 | Transfer outstanding |
| xfr_read | output | 1 | Transfer direction |
| xfr_dev | output | 7 | Transfer target address |
| xfr_size | output | 3 | Byte count minus one |
| xfr_op_ia | output | 1 | Offset-carrying operation select |
| xfr_ia_hi | output | 5 | Offset bits 7:3 |
| xfr_ia_lo | output | 3 | Offset bits 2:0 |
| xfr_ext_en | output | 1 | Two-byte offset enable |
| xfr_ext_ia | output | 8 | Offset bits 15:8 |
| xfr_data | output | 32 | Write data bits 31:0 |
| xfr_ext_data | output | 32 | Write data bits 63:32 |
| xfr_done | input | 1 | Transfer completed |
| xfr_ok | input | 1 | Completion succeeded |
| xfr_status | input | 8 | Failure status code |
| xfr_rdata | input | 32 | Read data from transfer |
| rcv_req | output | 1 | Bus-recovery request pulse |
| rcv_done | input | 1 | Bus recovery finished |

## Verification
The transfer completion and the timeout expiry can fall in the same cycle: the completion arrives exactly when the timeout counter reaches zero. The scripted transfer model is told to answer after exactly TIMEOUT_CYC cycles, which lands the completion on the last cycle of the window. The check requires that the command succeeds on its first transfer with no recovery request and no reissue, so completion must win over the timeout.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RCV_REQ,
    ST_RCV_WAIT,
    ST_BACKOFF,
    ST_FINISH
  } eng_state_t;

  typedef struct packed {
    logic        rd;
    logic [6:0]  dev;
    logic [15:0] ia;
    logic [1:0]  ia_len;
    logic [3:0]  nbytes;
    logic [63:0] wdata;
  } cmd_t;

  typedef struct packed {
    logic        rd;
    logic [6:0]  dev;
    logic [2:0]  size;
    logic        op_ia;
    logic [4:0]  ia_hi;
    logic [2:0]  ia_lo;
    logic        ext_en;
    logic [7:0]  ext_ia;
    logic [31:0] data;
    logic [31:0] ext_data;
  } xfr_fields_t;

  // Legal lengths: read 1..4, write 1..8, offset 0..2 bytes.
  function automatic logic cmd_legal(input cmd_t c);
    logic len_ok;
    len_ok = (c.nbytes != 4'd0) &&
             (c.rd ? (c.nbytes <= 4'd4) : (c.nbytes <= 4'd8));
    return len_ok && (c.ia_len != 2'd3);
  endfunction

  // Codes that mean another master won or the port is busy as a target.
  function automatic logic is_retry_code(input logic [7:0] st);
    case (st)
      8'h38, 8'h68, 8'h78, 8'h80, 8'h88,
      8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hC8: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // Keep the low nbytes bytes of a 32-bit read word.
  function automatic logic [31:0] rd_mask(input logic [3:0] nbytes);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 4; b++) begin
      if (b < int'(nbytes)) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/twi_cmd_timer.sv
module twi_cmd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/twi_cmd_classify.sv
module twi_cmd_classify
  import twi_cmd_pkg::*;
(
  input  logic       active,
  input  logic       done,
  input  logic       ok,
  input  logic [7:0] status,
  input  logic       tmr_zero,
  output logic       ev_ok,
  output logic       ev_retry,
  output logic       ev_fatal,
  output logic       ev_timeout
);
  logic seen;
  logic retry_code;

  assign seen       = active && done;
  assign retry_code = is_retry_code(status);
  assign ev_ok      = seen && ok;
  assign ev_retry   = seen && !ok && retry_code;
  assign ev_fatal   = seen && !ok && !retry_code;
  // Completion takes priority over an expiring window.
  assign ev_timeout = active && !done && tmr_zero;
endmodule

// File: rtl/twi_cmd_pack.sv
module twi_cmd_pack
  import twi_cmd_pkg::*;
(
  input  cmd_t        cmd,
  input  logic        poll_phase,
  output xfr_fields_t f
);
  logic has_ia;
  logic wide_ia;
  logic long_wr;

  assign has_ia  = (cmd.ia_len != 2'd0);
  assign wide_ia = (cmd.ia_len == 2'd2);
  assign long_wr = !cmd.rd && (cmd.nbytes > 4'd4);

  always_comb begin
    f     = '0;
    f.dev = cmd.dev;
    if (poll_phase) begin
      f.rd   = 1'b1;
      f.size = 3'd0;
    end else begin
      f.rd       = cmd.rd;
      f.size     = 3'(cmd.nbytes - 4'd1);
      f.op_ia    = has_ia;
      f.ia_hi    = has_ia  ? cmd.ia[7:3]  : 5'd0;
      f.ia_lo    = has_ia  ? cmd.ia[2:0]  : 3'd0;
      f.ext_en   = wide_ia;
      f.ext_ia   = wide_ia ? cmd.ia[15:8] : 8'd0;
      f.data     = cmd.rd  ? 32'd0 : cmd.wdata[31:0];
      f.ext_data = long_wr ? cmd.wdata[63:32] : 32'd0;
    end
  end
endmodule

// File: rtl/twi_cmd_engine.sv
module twi_cmd_engine
  import twi_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC     = 10000,
  parameter int RETRY_DELAY_CYC = 1000000,
  parameter int MAX_RETRY       = 5,
  parameter int POLL_MAX        = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_read,
  input  logic [6:0]  cmd_dev,
  input  logic [15:0] cmd_ia,
  input  logic [1:0]  cmd_ia_len,
  input  logic [3:0]  cmd_nbytes,
  input  logic [63:0] cmd_wdata,
  output logic        busy,
  output logic        res_done,
  output logic        res_err,
  output logic [31:0] res_rdata,
  output logic        xfr_issue,
  output logic        xfr_pending,
  output logic        xfr_read,
  output logic [6:0]  xfr_dev,
  output logic [2:0]  xfr_size,
  output logic        xfr_op_ia,
  output logic [4:0]  xfr_ia_hi,
  output logic [2:0]  xfr_ia_lo,
  output logic        xfr_ext_en,
  output logic [7:0]  xfr_ext_ia,
  output logic [31:0] xfr_data,
  output logic [31:0] xfr_ext_data,
  input  logic        xfr_done,
  input  logic        xfr_ok,
  input  logic [7:0]  xfr_status,
  input  logic [31:0] xfr_rdata,
  output logic        rcv_req,
  input  logic        rcv_done
);
  localparam int TMAX = (TIMEOUT_CYC > RETRY_DELAY_CYC) ? TIMEOUT_CYC : RETRY_DELAY_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);

  eng_state_t    state_q;
  cmd_t          cmd_q, cmd_in;
  logic          poll_phase;
  logic [RW-1:0] retry_cnt;
  logic [PW-1:0] poll_cnt;
  logic          err_q;
  logic [31:0]   rdata_q;
  xfr_fields_t   fld;

  // Named events, visible to the checker.
  logic ev_ok, ev_retry, ev_fatal, ev_timeout, ev_reject, ev_accept;
  logic ev_fail;
  logic tmr_load, tmr_run, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic budget_left, poll_left;

  assign cmd_in = '{rd: cmd_read, dev: cmd_dev, ia: cmd_ia, ia_len: cmd_ia_len,
                    nbytes: cmd_nbytes, wdata: cmd_wdata};

  assign ev_accept   = (state_q == ST_IDLE) && cmd_start && cmd_legal(cmd_in);
  assign ev_reject   = (state_q == ST_IDLE) && cmd_start && !cmd_legal(cmd_in);
  assign ev_fail     = ev_retry || ev_fatal;
  assign budget_left = (retry_cnt != '0);
  assign poll_left   = (poll_cnt != PW'(POLL_MAX));

  twi_cmd_classify u_cls (
    .active    (state_q == ST_WAIT),
    .done      (xfr_done),
    .ok        (xfr_ok),
    .status    (xfr_status),
    .tmr_zero  (tmr_zero),
    .ev_ok     (ev_ok),
    .ev_retry  (ev_retry),
    .ev_fatal  (ev_fatal),
    .ev_timeout(ev_timeout)
  );

  assign tmr_load = (state_q == ST_ISSUE) || (ev_retry && !poll_phase);
  assign tmr_val  = (state_q == ST_ISSUE) ? TW'(TIMEOUT_CYC) : TW'(RETRY_DELAY_CYC);
  assign tmr_run  = (state_q == ST_WAIT) || (state_q == ST_BACKOFF);

  twi_cmd_timer #(.W(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .run     (tmr_run),
    .zero    (tmr_zero)
  );

  twi_cmd_pack u_pack (
    .cmd       (cmd_q),
    .poll_phase(poll_phase),
    .f         (fld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '0;
      poll_phase <= 1'b0;
      retry_cnt  <= '0;
      poll_cnt   <= '0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ev_reject) begin
            cmd_q   <= cmd_in;
            err_q   <= 1'b1;
            rdata_q <= '0;
            state_q <= ST_FINISH;
          end else if (ev_accept) begin
            cmd_q      <= cmd_in;
            poll_phase <= 1'b0;
            retry_cnt  <= RW'(MAX_RETRY);
            poll_cnt   <= '0;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (ev_ok) begin
            if (poll_phase || cmd_q.rd) begin
              err_q   <= 1'b0;
              rdata_q <= poll_phase ? 32'd0 : (xfr_rdata & rd_mask(cmd_q.nbytes));
              state_q <= ST_FINISH;
            end else begin
              poll_phase <= 1'b1;
              poll_cnt   <= PW'(1);
              state_q    <= ST_ISSUE;
            end
          end else if (ev_fail && poll_phase) begin
            if (poll_left) begin
              poll_cnt <= poll_cnt + 1'b1;
              state_q  <= ST_ISSUE;
            end else begin
              err_q   <= 1'b1;
              rdata_q <= '0;
              state_q <= ST_FINISH;
            end
          end else if (ev_retry) begin
            state_q <= ST_BACKOFF;
          end else if (ev_fatal) begin
            err_q   <= 1'b1;
            rdata_q <= '0;
            state_q <= ST_FINISH;
          end else if (ev_timeout) begin
            state_q <= ST_RCV_REQ;
          end
        end
        ST_RCV_REQ: state_q <= ST_RCV_WAIT;
        ST_RCV_WAIT: begin
          if (rcv_done) begin
            if (poll_phase ? poll_left : budget_left) begin
              if (poll_phase) poll_cnt  <= poll_cnt + 1'b1;
              else            retry_cnt <= retry_cnt - 1'b1;
              state_q <= ST_ISSUE;
            end else begin
              err_q   <= 1'b1;
              rdata_q <= '0;
              state_q <= ST_FINISH;
            end
          end
        end
        ST_BACKOFF: begin
          if (tmr_zero) begin
            if (budget_left) begin
              retry_cnt <= retry_cnt - 1'b1;
              state_q   <= ST_ISSUE;
            end else begin
              err_q   <= 1'b1;
              rdata_q <= '0;
              state_q <= ST_FINISH;
            end
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign res_done     = (state_q == ST_FINISH);
  assign res_err      = err_q;
  assign res_rdata    = rdata_q;
  assign xfr_issue    = (state_q == ST_ISSUE);
  assign xfr_pending  = (state_q == ST_WAIT);
  assign rcv_req      = (state_q == ST_RCV_REQ);
  assign xfr_read     = fld.rd;
  assign xfr_dev      = fld.dev;
  assign xfr_size     = fld.size;
  assign xfr_op_ia    = fld.op_ia;
  assign xfr_ia_hi    = fld.ia_hi;
  assign xfr_ia_lo    = fld.ia_lo;
  assign xfr_ext_en   = fld.ext_en;
  assign xfr_ext_ia   = fld.ext_ia;
  assign xfr_data     = fld.data;
  assign xfr_ext_data = fld.ext_data;
endmodule

// File: rtl/twi_cmd_engine_chk.sv
module twi_cmd_engine_chk #(
  parameter int MAX_RETRY = 5,
  parameter int RW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfr_issue,
  input logic          xfr_read,
  input logic [2:0]    xfr_size,
  input logic          xfr_op_ia,
  input logic          xfr_ext_en,
  input logic          rcv_req,
  input logic          res_done,
  input logic          res_err,
  input logic          busy,
  input logic          ev_reject,
  input logic          ev_timeout,
  input logic          ev_retry,
  input logic          ev_fatal,
  input logic          poll_phase,
  input logic [RW-1:0] retry_cnt
);
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (res_done && res_err && !xfr_issue)); // R1

  AST_EXT_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_issue && xfr_ext_en) |-> xfr_op_ia); // R3

  AST_TIMEOUT_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> rcv_req); // R5

  AST_BACKOFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retry && !poll_phase) |=> (!xfr_issue && !res_done)); // R6

  AST_FATAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fatal && !poll_phase) |=> (res_done && res_err)); // R7

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RW'(MAX_RETRY)); // R8

  AST_POLL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_issue && poll_phase) |-> (xfr_read && xfr_size == 3'd0 && !xfr_op_ia)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done); // R12

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> busy); // R12
endmodule

bind twi_cmd_engine twi_cmd_engine_chk #(.MAX_RETRY(MAX_RETRY), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfr_issue(xfr_issue), .xfr_read(xfr_read),
  .xfr_size(xfr_size), .xfr_op_ia(xfr_op_ia), .xfr_ext_en(xfr_ext_en),
  .rcv_req(rcv_req), .res_done(res_done), .res_err(res_err), .busy(busy),
  .ev_reject(ev_reject), .ev_timeout(ev_timeout), .ev_retry(ev_retry),
  .ev_fatal(ev_fatal), .poll_phase(poll_phase), .retry_cnt(retry_cnt)
);

// File: tb/sim_twi_cmd_engine.sv
`timescale 1ns/1ps
module sim_twi_cmd_engine;
  localparam int T  = 40;
  localparam int D  = 30;
  localparam int MR = 5;
  localparam int PM = 6;
  localparam int K_OK = 0, K_FAIL = 1, K_HANG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_start = 1'b0, cmd_read = 1'b0;
  logic [6:0]  cmd_dev = '0;
  logic [15:0] cmd_ia = '0;
  logic [1:0]  cmd_ia_len = '0;
  logic [3:0]  cmd_nbytes = '0;
  logic [63:0] cmd_wdata = '0;
  logic busy, res_done, res_err, xfr_issue, xfr_pending, xfr_read, xfr_op_ia, xfr_ext_en, rcv_req;
  logic [31:0] res_rdata, xfr_data, xfr_ext_data, xfr_rdata;
  logic [6:0]  xfr_dev;
  logic [2:0]  xfr_size, xfr_ia_lo;
  logic [4:0]  xfr_ia_hi;
  logic [7:0]  xfr_ext_ia, xfr_status;
  logic        xfr_done, xfr_ok, rcv_done;

  twi_cmd_engine #(.TIMEOUT_CYC(T), .RETRY_DELAY_CYC(D), .MAX_RETRY(MR), .POLL_MAX(PM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_dev(cmd_dev),
    .cmd_ia(cmd_ia), .cmd_ia_len(cmd_ia_len), .cmd_nbytes(cmd_nbytes), .cmd_wdata(cmd_wdata),
    .busy(busy), .res_done(res_done), .res_err(res_err), .res_rdata(res_rdata),
    .xfr_issue(xfr_issue), .xfr_pending(xfr_pending), .xfr_read(xfr_read), .xfr_dev(xfr_dev),
    .xfr_size(xfr_size), .xfr_op_ia(xfr_op_ia), .xfr_ia_hi(xfr_ia_hi), .xfr_ia_lo(xfr_ia_lo),
    .xfr_ext_en(xfr_ext_en), .xfr_ext_ia(xfr_ext_ia), .xfr_data(xfr_data),
    .xfr_ext_data(xfr_ext_data), .xfr_done(xfr_done), .xfr_ok(xfr_ok), .xfr_status(xfr_status),
    .xfr_rdata(xfr_rdata), .rcv_req(rcv_req), .rcv_done(rcv_done));

  // Scripted transfer layer.
  int          sk_kind [16];
  logic [7:0]  sk_stat [16];
  int          sk_dly  [16];
  logic [31:0] sk_rd   [16];
  logic [7:0]  base = '0;

  logic [7:0]  att, cur;
  logic        active;
  int          cnt, cyc, rcv_total, rc;
  logic        cp_rd [64], cp_op [64], cp_ee [64];
  logic [6:0]  cp_dev [64];
  logic [2:0]  cp_sz [64], cp_lo [64];
  logic [4:0]  cp_hi [64];
  logic [7:0]  cp_eia [64];
  logic [31:0] cp_d [64], cp_ed [64];
  int          iss_cyc [64], done_cyc [64];
  logic [3:0]  sidx;

  assign sidx       = 4'(cur - base);
  assign xfr_done   = active && (sk_kind[sidx] != K_HANG) && (cnt == sk_dly[sidx]);
  assign xfr_ok     = (sk_kind[sidx] == K_OK);
  assign xfr_status = sk_stat[sidx];
  assign xfr_rdata  = sk_rd[sidx];
  assign rcv_done   = (rc == 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att <= '0; cur <= '0; active <= 1'b0; cnt <= 0; cyc <= 0; rcv_total <= 0; rc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (rcv_req) begin rcv_total <= rcv_total + 1; rc <= 3; end
      else if (rc != 0) rc <= rc - 1;
      if (xfr_issue) begin
        cp_rd[att[5:0]] <= xfr_read;  cp_dev[att[5:0]] <= xfr_dev;  cp_sz[att[5:0]] <= xfr_size;
        cp_op[att[5:0]] <= xfr_op_ia; cp_hi[att[5:0]] <= xfr_ia_hi; cp_lo[att[5:0]] <= xfr_ia_lo;
        cp_ee[att[5:0]] <= xfr_ext_en; cp_eia[att[5:0]] <= xfr_ext_ia;
        cp_d[att[5:0]] <= xfr_data;   cp_ed[att[5:0]] <= xfr_ext_data;
        iss_cyc[att[5:0]] <= cyc;
        cur <= att; att <= att + 1'b1; active <= 1'b1; cnt <= 0;
      end else if (active) begin
        if (xfr_done) begin active <= 1'b0; done_cyc[cur[5:0]] <= cyc; end
        cnt <= cnt + 1;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  logic r_err;
  logic [31:0] r_data;

  task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_script();
    base = att;
    for (int i = 0; i < 16; i++) begin
      sk_kind[i] = K_OK; sk_stat[i] = 8'h00; sk_dly[i] = 5; sk_rd[i] = '0;
    end
  endtask

  task automatic put(input int i, input int k, input logic [7:0] st, input int dl, input logic [31:0] rd);
    sk_kind[i] = k; sk_stat[i] = st; sk_dly[i] = dl; sk_rd[i] = rd;
  endtask

  task automatic start_cmd(input logic rd, input logic [6:0] dev, input logic [15:0] ia,
                           input logic [1:0] il, input logic [3:0] nb, input logic [63:0] wd);
    @(negedge clk);
    cmd_start = 1'b1; cmd_read = rd; cmd_dev = dev; cmd_ia = ia;
    cmd_ia_len = il; cmd_nbytes = nb; cmd_wdata = wd;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  // Wait for the result pulse; also checks it lasts exactly one cycle (R12).
  task automatic wait_res();
    int guard = 0;
    while (!res_done && guard < 20000) begin @(negedge clk); guard++; end
    chk(res_done, "R12 result arrives", 0, 1);
    r_err = res_err; r_data = res_rdata;
    @(negedge clk);
    chk(!res_done, "R12 done is one cycle", 64'(res_done), 0);
    chk(!busy, "R12 idle after done", 64'(busy), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !res_done && !xfr_issue && !rcv_req, "R12 reset state", {busy, res_done, xfr_issue}, 0);
  endtask

  task automatic t_reject();
    logic [7:0] a0;
    a0 = att;
    start_cmd(1'b1, 7'h10, 16'h0, 2'd0, 4'd5, 64'h0);
    chk(res_done && res_err, "R1 read of 5 rejected", {res_done, res_err}, 2'b11);
    wait_res();
    start_cmd(1'b0, 7'h10, 16'h0, 2'd0, 4'd9, 64'h0);
    chk(res_done && res_err, "R1 write of 9 rejected", {res_done, res_err}, 2'b11);
    wait_res();
    start_cmd(1'b1, 7'h10, 16'h0, 2'd0, 4'd0, 64'h0);
    wait_res();
    chk(r_err, "R1 zero length rejected", 64'(r_err), 1);
    start_cmd(1'b1, 7'h10, 16'h0, 2'd3, 4'd1, 64'h0);
    wait_res();
    chk(r_err, "R1 offset code 3 rejected", 64'(r_err), 1);
    chk(att == a0, "R1 no transfer issued", 64'(att - a0), 0);
  endtask

  task automatic t_read_wide();
    logic [5:0] i;
    clear_script();
    put(0, K_OK, 8'h00, 5, 32'hDEADBEEF);
    i = att[5:0];
    start_cmd(1'b1, 7'h52, 16'hA5C3, 2'd2, 4'd3, 64'h0);
    wait_res();
    chk(!r_err, "R9 three-byte read ok", 64'(r_err), 0);
    chk(r_data == 32'h00ADBEEF, "R9 read masked to 3 bytes", r_data, 32'h00ADBEEF);
    chk(cp_rd[i] && cp_dev[i] == 7'h52 && cp_sz[i] == 3'd2, "R2 dir/dev/size",
        {cp_rd[i], cp_dev[i], cp_sz[i]}, {1'b1, 7'h52, 3'd2});
    chk(cp_op[i] && cp_hi[i] == 5'h18 && cp_lo[i] == 3'd3, "R3 offset split",
        {cp_op[i], cp_hi[i], cp_lo[i]}, {1'b1, 5'h18, 3'd3});
    chk(cp_ee[i] && cp_eia[i] == 8'hA5, "R3 extension byte", {cp_ee[i], cp_eia[i]}, {1'b1, 8'hA5});
  endtask

  task automatic t_read_narrow();
    logic [5:0] i;
    clear_script();
    put(0, K_OK, 8'h00, 7, 32'h89ABCDEF);
    i = att[5:0];
    start_cmd(1'b1, 7'h21, 16'h1234, 2'd1, 4'd4, 64'h0);
    wait_res();
    chk(r_data == 32'h89ABCDEF, "R9 four-byte read unmasked", r_data, 32'h89ABCDEF);
    chk(cp_op[i] && cp_hi[i] == 5'h06 && cp_lo[i] == 3'd4 && !cp_ee[i] && cp_eia[i] == 8'h0,
        "R3 one-byte offset", {cp_op[i], cp_hi[i], cp_lo[i], cp_ee[i]}, {1'b1, 5'h06, 3'd4, 1'b0});
    clear_script();
    put(0, K_OK, 8'h00, 3, 32'hFFFFFFFF);
    start_cmd(1'b1, 7'h21, 16'h0, 2'd0, 4'd1, 64'h0);
    wait_res();
    chk(r_data == 32'h000000FF, "R9 one-byte read masked", r_data, 32'hFF);
  endtask

  task automatic t_write_long();
    logic [5:0] i;
    clear_script();
    put(0, K_OK, 8'h00, 5, 32'h0);
    put(1, K_FAIL, 8'h48, 4, 32'h0);
    put(2, K_OK, 8'h00, 4, 32'h0);
    i = att[5:0];
    start_cmd(1'b0, 7'h33, 16'h0, 2'd0, 4'd6, 64'h1122334455667788);
    wait_res();
    chk(!r_err, "R10 write then poll succeeds", 64'(r_err), 0);
    chk(att - base == 3, "R10 one failed poll then success", 64'(att - base), 3);
    chk(!cp_rd[i] && cp_sz[i] == 3'd5 && !cp_op[i] && cp_hi[i] == 0 && !cp_ee[i],
        "R2 write fields", {cp_rd[i], cp_sz[i], cp_op[i]}, {1'b0, 3'd5, 1'b0});
    chk(cp_d[i] == 32'h55667788 && cp_ed[i] == 32'h11223344, "R4 long write data",
        {cp_ed[i], cp_d[i]}, 64'h1122334455667788);
    chk(cp_rd[i+1] && cp_sz[i+1] == 0 && !cp_op[i+1] && cp_dev[i+1] == 7'h33 && cp_d[i+1] == 0,
        "R10 poll transfer shape", {cp_rd[i+1], cp_sz[i+1], cp_op[i+1]}, {1'b1, 3'd0, 1'b0});
  endtask

  task automatic t_write_short();
    logic [5:0] i;
    clear_script();
    i = att[5:0];
    start_cmd(1'b0, 7'h0F, 16'h0, 2'd0, 4'd3, 64'hAABBCCDD_00C0FFEE);
    wait_res();
    chk(cp_d[i] == 32'h00C0FFEE && cp_ed[i] == 32'h0, "R4 short write, extension zero",
        {cp_ed[i], cp_d[i]}, 64'h0000000000C0FFEE);
  endtask

  task automatic t_timeout();
    int r0;
    clear_script();
    put(0, K_HANG, 8'h00, 0, 32'h0);
    put(1, K_OK, 8'h00, 5, 32'h000000AB);
    r0 = rcv_total;
    start_cmd(1'b1, 7'h44, 16'h0, 2'd0, 4'd1, 64'h0);
    wait_res();
    chk(!r_err && r_data == 32'hAB, "R5 retry after recovery succeeds", r_data, 32'hAB);
    chk(rcv_total - r0 == 1, "R5 one recovery request", 64'(rcv_total - r0), 1);
    chk(att - base == 2, "R5 reissued once", 64'(att - base), 2);
  endtask

  // Completion and timeout expiry in the same cycle.
  task automatic t_edge();
    int r0;
    clear_script();
    put(0, K_OK, 8'h00, T, 32'h00000055);
    r0 = rcv_total;
    start_cmd(1'b1, 7'h44, 16'h0, 2'd0, 4'd1, 64'h0);
    wait_res();
    chk(!r_err && r_data == 32'h55, "R5 completion in last window cycle wins", r_data, 32'h55);
    chk(rcv_total == r0 && att - base == 1, "R5 no recovery at window edge", 64'(rcv_total - r0), 0);
  endtask

  task automatic t_backoff();
    int gap;
    logic [5:0] i;
    clear_script();
    put(0, K_FAIL, 8'hB0, 5, 32'h0);
    put(1, K_OK, 8'h00, 5, 32'h00001234);
    i = att[5:0];
    start_cmd(1'b1, 7'h60, 16'h0, 2'd0, 4'd2, 64'h0);
    wait_res();
    gap = iss_cyc[i+1] - done_cyc[i];
    chk(!r_err && r_data == 32'h1234, "R6 retried after back-off", r_data, 32'h1234);
    chk(gap >= D && gap <= D + 3, "R6 back-off length", 64'(gap), 64'(D + 2));
  endtask

  task automatic t_fatal();
    clear_script();
    put(0, K_FAIL, 8'h20, 5, 32'h0);
    start_cmd(1'b1, 7'h61, 16'h0, 2'd0, 4'd1, 64'h0);
    wait_res();
    chk(r_err, "R7 unknown status errors", 64'(r_err), 1);
    chk(att - base == 1, "R7 no reissue", 64'(att - base), 1);
  endtask

  task automatic t_budget();
    int r0;
    clear_script();
    put(0, K_HANG, 8'h00, 0, 0); put(1, K_FAIL, 8'h38, 5, 0);
    put(2, K_HANG, 8'h00, 0, 0); put(3, K_FAIL, 8'h80, 5, 0);
    put(4, K_HANG, 8'h00, 0, 0); put(5, K_FAIL, 8'hC8, 5, 0);
    put(6, K_OK, 8'h00, 5, 0);
    r0 = rcv_total;
    start_cmd(1'b1, 7'h62, 16'h0, 2'd0, 4'd1, 64'h0);
    wait_res();
    chk(r_err, "R8 error after budget spent", 64'(r_err), 1);
    chk(att - base == MR + 1, "R8 initial plus MAX_RETRY transfers", 64'(att - base), 64'(MR + 1));
    chk(rcv_total - r0 == 3, "R8 recoveries counted in budget", 64'(rcv_total - r0), 3);
  endtask

  task automatic t_poll_exhaust();
    clear_script();
    for (int k = 1; k <= PM; k++) put(k, K_FAIL, 8'h48, 4, 0);
    start_cmd(1'b0, 7'h63, 16'h0, 2'd0, 4'd1, 64'h5A);
    wait_res();
    chk(r_err, "R10 poll limit gives error", 64'(r_err), 1);
    chk(att - base == PM + 1, "R10 POLL_MAX polls issued", 64'(att - base), 64'(PM + 1));
  endtask

  task automatic t_busy();
    clear_script();
    put(0, K_OK, 8'h00, 20, 32'hCAFEF00D);
    start_cmd(1'b1, 7'h64, 16'h0, 2'd0, 4'd4, 64'h0);
    repeat (4) @(negedge clk);
    chk(busy, "R12 busy during command", 64'(busy), 1);
    cmd_start = 1'b1; cmd_read = 1'b1; cmd_ia_len = 2'd3; cmd_nbytes = 4'd1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(!res_done, "R11 start ignored while busy", 64'(res_done), 0);
    wait_res();
    chk(!r_err && r_data == 32'hCAFEF00D, "R11 running command unaffected", r_data, 32'hCAFEF00D);
    chk(att - base == 1, "R11 no extra transfer", 64'(att - base), 1);
  endtask

  initial begin
    clear_script();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_read_wide();
    t_read_narrow();
    t_write_long();
    t_write_short();
    t_timeout();
    t_edge();
    t_backoff();
    t_fatal();
    t_budget();
    t_poll_exhaust();
    t_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule